// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block watches the four active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring and carrier-detect. It reports their present asserted state in the upper nibble of an 8-bit status word. It also keeps one sticky change flag per line in the lower nibble. The host reads the word, and a read strobe clears the change flags. The modem-status interrupt request stays high while any change flag is set.

Each pin is first brought into the clock domain by a chain of synchronizer flops. A change flag is set by a change of the synchronized level in either direction, except for the ring flag. The ring flag is set only when the ring indication ends, that is, when the pin returns high. In loopback mode the asserted-state nibble is taken from the four modem-control outputs (RTS, DTR, OUT1, OUT2) in place of the pins, and the change flags follow those looped values.

Top module: `modem_status_unit`

## Requirements
- R1: In normal mode, status bits 4, 5, 6 and 7 equal the inverted synchronized level of the CTS, DSR, RI and DCD pins. Each bit shows a pin change after the second rising clock edge.
- R2: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) become 1 when the matching pin changes in either direction. The bit is set on the third rising edge after the pin change.
- R3: Status bit 2 becomes 1 only when the RI pin goes from 0 to 1. A 1-to-0 transition of RI leaves bit 2 at 0.
- R4: A cycle with the read strobe high clears bits 0 to 3 at the next rising edge, unless a new change arrives in that same cycle.
- R5: A change detected in the same cycle as the read strobe keeps its flag at 1 after the read.
- R6: The interrupt output is 1 exactly when at least one of status bits 0 to 3 is 1.
- R7: With loopback enabled, bits 4, 5, 6 and 7 equal the RTS, DTR, OUT1 and OUT2 inputs in the same cycle. The pins then have no effect on the status word.
- R8: With loopback enabled, the change flags are computed from the looped values and are set on the first rising edge after the change. OUT1 going from 1 to 0 sets bit 2, and OUT1 going from 0 to 1 does not.
- R9: During and after reset, with the pins held high and loopback off, the status word is 0x00 and the interrupt output is 0.
- R10: A set change flag stays 1 until a read strobe, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_pin | input | 1 | Ring pin, active low, asynchronous |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Selects the looped modem-control values in place of the pins |
| loop_rts | input | 1 | Looped RTS, shown in bit 4 |
| loop_dtr | input | 1 | Looped DTR, shown in bit 5 |
| loop_out1 | input | 1 | Looped OUT1, shown in bit 6 |
| loop_out2 | input | 1 | Looped OUT2, shown in bit 7 |
| rd_strobe | input | 1 | One-cycle read of the status word; clears the change flags |
| status | output | 8 | Asserted-state nibble [7:4] and change flags [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
If the previous-level register is corrupted, a false change flag and a false interrupt appear one edge later. A bad synchronizer stage shows as the upper nibble moving one cycle early or late against the pin. If the flag update logic drops the read-versus-change priority, a flag reads 0 one edge after a read that coincided with a change. A wrong ring edge polarity shows as bit 2 set while the ring is still active. A slip in the loopback crossing shows as a wrong bit in the same cycle that loopback values are driven.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned LINES = 4;
  // Line order inside every nibble: the position is what the status word decodes.
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_DCD = 3;
  // Lines whose flag fires only when the asserted level drops.
  localparam logic [LINES-1:0] FALL_ONLY = 4'b0100;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         rd,
  output logic [N-1:0] flags
);
  logic [N-1:0] prev_q, flag_q, flag_d, hit;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (FALL_MASK[i]) begin : g_fall
      assign hit[i] = prev_q[i] & ~lvl[i];
    end else begin : g_any
      assign hit[i] = prev_q[i] ^ lvl[i];
    end
  end

  always_comb begin
    flag_d = (flag_q & ~{N{rd}}) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

  // R2 / R8: a detected change sets its flag at the next edge.
  a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));
  // R4: a read with no new change empties all flags.
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit == '0) |=> (flag_q == '0));
  // R10: set flags survive cycles without a read.
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R3: a clear flag on a fall-only line is not set when the level rises.
  for (genvar j = 0; j < N; j++) begin : g_chk
    if (FALL_MASK[j]) begin : g_f
      a_r3_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_q[j] && lvl[j] && !flag_q[j]) |=> !flag_q[j]);
    end
  end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_pin,
  input  logic       dsr_n_pin,
  input  logic       ri_n_pin,
  input  logic       dcd_n_pin,
  input  logic       loop_en,
  input  logic       loop_rts,
  input  logic       loop_dtr,
  input  logic       loop_out1,
  input  logic       loop_out2,
  input  logic       rd_strobe,
  output logic [7:0] status,
  output logic       irq
);
  logic [LINES-1:0] pin_raw_n, pin_sync_n, pin_lvl, loop_lvl, cur_lvl, flags;

  always_comb begin
    pin_raw_n          = '0;
    pin_raw_n[L_CTS]   = cts_n_pin;
    pin_raw_n[L_DSR]   = dsr_n_pin;
    pin_raw_n[L_RI]    = ri_n_pin;
    pin_raw_n[L_DCD]   = dcd_n_pin;
    loop_lvl           = '0;
    loop_lvl[L_CTS]    = loop_rts;
    loop_lvl[L_DSR]    = loop_dtr;
    loop_lvl[L_RI]     = loop_out1;
    loop_lvl[L_DCD]    = loop_out2;
  end

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw_n), .q(pin_sync_n)
  );

  assign pin_lvl = ~pin_sync_n;
  assign cur_lvl = loop_en ? loop_lvl : pin_lvl;

  msr_change_det #(.N(LINES), .FALL_MASK(FALL_ONLY)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(cur_lvl), .rd(rd_strobe), .flags(flags)
  );

  assign status = {cur_lvl, flags};
  assign irq    = |flags;

  // R7: in loopback the pins cannot move the asserted-state nibble.
  a_r7_loop_ignores_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && $stable(loop_en) && $stable(loop_lvl)) |-> $stable(status[7:4]));
  // R6: interrupt falls only together with the last flag.
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status[3:0] == 4'h0));
endmodule

// File: tb/tb_modem_status_unit.sv
module tb_modem_status_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic lb = 0, rts = 0, dtr = 0, out1 = 0, out2 = 0, rd = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_unit dut (
    .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n), .dsr_n_pin(dsr_n),
    .ri_n_pin(ri_n), .dcd_n_pin(dcd_n), .loop_en(lb), .loop_rts(rts),
    .loop_dtr(dtr), .loop_out1(out1), .loop_out2(out2), .rd_strobe(rd),
    .status(status), .irq(irq)
  );

  // pins {dcd,ri,dsr,cts} (active low), expected status, expected irq
  localparam logic [12:0] VEC [6] = '{
    {4'b1110, 8'h11, 1'b1},  // R1 R2: CTS asserted
    {4'b1111, 8'h01, 1'b1},  // R2: CTS released
    {4'b1011, 8'h40, 1'b0},  // R3: ring starts, no flag
    {4'b1111, 8'h04, 1'b1},  // R3: ring ends, flag
    {4'b0101, 8'hAA, 1'b1},  // R1 R2: DCD and DSR asserted
    {4'b1111, 8'h0A, 1'b1}   // R2: both released
  };

  task automatic chk(input string req, input logic [7:0] exp_s, input logic exp_i);
    checks++;
    if (status !== exp_s || irq !== exp_i) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b", req, status, irq, exp_s, exp_i);
    end
  endtask

  task automatic do_read();
    rd = 1; @(negedge clk); rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 in reset", 8'h00, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 after reset", 8'h00, 1'b0);

    foreach (VEC[k]) begin
      {dcd_n, ri_n, dsr_n, cts_n} = VEC[k][12:9];
      @(negedge clk);
      @(negedge clk);
      chk("R1 level after two edges", {VEC[k][8:5], 4'h0}, 1'b0);
      @(negedge clk);
      chk("R2/R3 vector", VEC[k][8:1], VEC[k][0]);
      do_read();
      chk("R4 read clears", {VEC[k][8:5], 4'h0}, 1'b0);
    end

    // R10 sticky
    cts_n = 0; repeat (3) @(negedge clk);
    repeat (12) @(negedge clk);
    chk("R10 sticky", 8'h11, 1'b1);
    do_read();
    cts_n = 1; repeat (3) @(negedge clk);
    do_read();
    chk("R4 cleared", 8'h00, 1'b0);

    // Loopback
    lb = 1;
    @(negedge clk);
    chk("R7 loop idle", 8'h00, 1'b0);
    rts = 1; dtr = 0; out1 = 0; out2 = 1;
    #1 chk("R7 loop map same cycle", 8'h90, 1'b0);
    @(negedge clk);
    chk("R8 loop deltas one edge", 8'h99, 1'b1);
    do_read();
    chk("R4 loop read", 8'h90, 1'b0);
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0;
    repeat (4) @(negedge clk);
    chk("R7 pins ignored", 8'h90, 1'b0);
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1;
    repeat (4) @(negedge clk);
    chk("R7 pins ignored on release", 8'h90, 1'b0);
    out1 = 1; @(negedge clk);
    chk("R8 out1 rise no flag", 8'hD0, 1'b0);
    out1 = 0; @(negedge clk);
    chk("R8 out1 fall sets bit2", 8'h94, 1'b1);
    do_read();
    // R5: change in the same cycle as the read
    rts = 0; rd = 1; @(negedge clk); rd = 0;
    chk("R5 change during read kept", 8'h81, 1'b1);
    do_read();
    chk("R6 irq low after clear", 8'h80, 1'b0);
    rts = 0; dtr = 0; out1 = 0; out2 = 0;
    @(negedge clk);
    do_read();
    lb = 0;
    repeat (3) @(negedge clk);
    chk("R9 idle again", 8'h00, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule